// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block is one 9-bit slice of a transceiver that links two buses, called A and B. Each side has a storage register. Two output-enable controls set which side is driven, or leave both undriven so the buses are isolated. Two select lines decide, separately for each direction, whether a driven side carries the live data from the opposite side or the opposite side's stored register value.

Tri-state pins are split into input, output and output-enable vectors. The pad ring resolves them, so the slice stays synthesizable. An output that is not enabled reads zero. Each register loads the resolved value of its own bus pin on the rising edge of its own clock, whatever the enables are set to. A register can therefore load data that this slice itself is driving onto its pin. That is how one value gets stored on both sides. The two clocks are independent domains with no synchronisation between them.

The live path always takes the opposite side's external input, never the resolved pin value. This keeps the slice free of combinational loops.

Top module: `regbus_xcvr`

## Requirements
- R1: The active-low asynchronous reset `rst_ni` clears both storage registers to zero.
- R2: `b_oe_o` is 1 exactly when `oe_ab_i` is 1. `a_oe_o` is 1 exactly when `oe_ba_n_i` is 0. With `oe_ab_i`=0 and `oe_ba_n_i`=1, both enables are 0 (isolation).
- R3: On each rising edge of `clk_ab_i`, the A register loads the resolved A pin: `a_o` if `a_oe_o` is 1, otherwise `a_i`. On each rising edge of `clk_ba_i`, the B register loads the resolved B pin in the same way.
- R4: Capture happens whether the output enables are set for isolation, for one direction, or for both directions.
- R5: While B is driven, `sel_ab_i`=0 puts the live `a_i` on `b_o`, and `sel_ab_i`=1 puts the stored A register on `b_o`.
- R6: While A is driven, `sel_ba_i`=0 puts the live `b_i` on `a_o`, and `sel_ba_i`=1 puts the stored B register on `a_o`.
- R7: With `oe_ab_i`=1, `oe_ba_n_i`=0, `sel_ab_i`=1 and `sel_ba_i`=1, both sides are driven. `b_o` carries the stored A value and `a_o` carries the stored B value.
- R8: When A is driven live from B, a `clk_ab_i` edge stores `b_i` in the A register. Together with a `clk_ba_i` edge on the same instant, one value lands in both registers.
- R9: An output whose enable is 0 reads all zeros.
- R10: When a side is driven from the stored register, a clock edge on that side reloads the driven (stored) value. Loading a new value into both registers then needs clock edges at separate instants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab_i | input | 1 | Capture clock of the A register |
| clk_ba_i | input | 1 | Capture clock of the B register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_ab_i | input | 1 | Drive B side when 1 |
| oe_ba_n_i | input | 1 | Drive A side when 0 |
| sel_ab_i | input | 1 | B source: 0 live A, 1 stored A |
| sel_ba_i | input | 1 | A source: 0 live B, 1 stored B |
| a_i | input | 9 | External value on A pins |
| a_o | output | 9 | Data driven onto A pins |
| a_oe_o | output | 1 | A pin output enable |
| b_i | input | 9 | External value on B pins |
| b_o | output | 9 | Data driven onto B pins |
| b_oe_o | output | 1 | B pin output enable |

## Verification
A register that loads the wrong value stays hidden until a select line picks the stored path. From then on the fault is visible on the opposite output in the same cycle. The bench therefore follows every capture with a both-sides stored exchange, which exposes both registers at once. A capture that takes the external input instead of the resolved pin value only shows when a driven side is clocked. Such a fault appears as a mismatch at the first stored readout after the loop-back captures that R8 and R10 exercise.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_drive_path.sv
module xcvr_drive_path
  import xcvr_pkg::*;
#(
  parameter int W = 9
) (
  input  logic         en_i,
  input  src_sel_e     src_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  output logic [W-1:0] data_o,
  output logic         oe_o
);
  logic [W-1:0] picked;

  always_comb begin
    unique case (src_i)
      SRC_STORED: picked = stored_i;
      default:    picked = live_i;
    endcase
  end

  assign oe_o   = en_i;
  assign data_o = en_i ? picked : '0;

  // undriven side reads zero
  always_comb begin
    if (!oe_o) assert_idle_zero_R9: assert (data_o == '0);
  end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import xcvr_pkg::*;
#(
  parameter int W = 9
) (
  input  logic         clk_ab_i,
  input  logic         clk_ba_i,
  input  logic         rst_ni,
  input  logic         oe_ab_i,
  input  logic         oe_ba_n_i,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic         b_oe_o
);
  logic [W-1:0] reg_a, reg_b;
  logic [W-1:0] a_pin, b_pin;

  // A -> B direction
  xcvr_drive_path #(.W(W)) u_path_ab (
    .en_i    (oe_ab_i),
    .src_i   (src_sel_e'(sel_ab_i)),
    .live_i  (a_i),
    .stored_i(reg_a),
    .data_o  (b_o),
    .oe_o    (b_oe_o)
  );

  // B -> A direction
  xcvr_drive_path #(.W(W)) u_path_ba (
    .en_i    (!oe_ba_n_i),
    .src_i   (src_sel_e'(sel_ba_i)),
    .live_i  (b_i),
    .stored_i(reg_b),
    .data_o  (a_o),
    .oe_o    (a_oe_o)
  );

  // resolved pin: own drive wins over external input
  assign a_pin = a_oe_o ? a_o : a_i;
  assign b_pin = b_oe_o ? b_o : b_i;

  xcvr_store_reg #(.W(W)) u_reg_a (
    .clk_i (clk_ab_i),
    .rst_ni(rst_ni),
    .d_i   (a_pin),
    .q_o   (reg_a)
  );

  xcvr_store_reg #(.W(W)) u_reg_b (
    .clk_i (clk_ba_i),
    .rst_ni(rst_ni),
    .d_i   (b_pin),
    .q_o   (reg_b)
  );

  // stored A seen on B equals pin value at previous clk_ab edge
  assert_capture_a_R3: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    1'b1 |=> (!(oe_ab_i && sel_ab_i) || b_o == $past(a_pin)));

  assert_capture_b_R3: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    1'b1 |=> (oe_ba_n_i || !sel_ba_i || a_o == $past(b_pin)));

  always_comb begin
    if (!oe_ab_i && oe_ba_n_i)
      assert_isolation_R2: assert (!a_oe_o && !b_oe_o);
    if (oe_ab_i && !oe_ba_n_i && sel_ab_i && sel_ba_i)
      assert_exchange_R7: assert (a_oe_o && b_oe_o && b_o == reg_a && a_o == reg_b);
  end
endmodule

// File: tb/regbus_xcvr_bench.sv
module regbus_xcvr_bench;
  localparam int W = 9;

  typedef struct {
    logic         a_oe;
    logic         b_oe;
    logic [W-1:0] a_o;
    logic [W-1:0] b_o;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
  logic         oe_ab = 1'b0, oe_ba_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  logic [W-1:0] m_ra = '0, m_rb = '0;
  exp_t         q[$];
  int           checks = 0, errors = 0, cycles = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  regbus_xcvr #(.W(W)) u_regbus_xcvr (
    .clk_ab_i(clk_ab), .clk_ba_i(clk_ba), .rst_ni(rst_n),
    .oe_ab_i(oe_ab), .oe_ba_n_i(oe_ba_n), .sel_ab_i(sel_ab), .sel_ba_i(sel_ba),
    .a_i(a_in), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_in), .b_o(b_out), .b_oe_o(b_oe)
  );

  function automatic exp_t model(string tag);
    exp_t e;
    e.a_oe = !oe_ba_n;
    e.b_oe = oe_ab;
    e.a_o  = e.a_oe ? (sel_ba ? m_rb : b_in) : '0;
    e.b_o  = e.b_oe ? (sel_ab ? m_ra : a_in) : '0;
    e.tag  = tag;
    return e;
  endfunction

  task automatic step(input string tag, input logic oab, input logic oban,
                      input logic sab, input logic sba,
                      input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic pab, input logic pba);
    exp_t pre;
    logic [W-1:0] ap, bp;
    @(posedge clk);
    oe_ab = oab; oe_ba_n = oban; sel_ab = sab; sel_ba = sba; a_in = a; b_in = b;
    pre = model(tag);
    ap = pre.a_oe ? pre.a_o : a;
    bp = pre.b_oe ? pre.b_o : b;
    #1;
    if (pab) clk_ab = 1'b1;
    if (pba) clk_ba = 1'b1;
    #1;
    clk_ab = 1'b0; clk_ba = 1'b0;
    if (pab) m_ra = ap;
    if (pba) m_rb = bp;
    q.push_back(model(tag));
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (a_oe !== e.a_oe || b_oe !== e.b_oe || a_out !== e.a_o || b_out !== e.b_o) begin
        errors++;
        $display("FAIL %s: got a_oe=%b b_oe=%b a_o=%h b_o=%h exp a_oe=%b b_oe=%b a_o=%h b_o=%h",
                 e.tag, a_oe, b_oe, a_out, b_out, e.a_oe, e.b_oe, e.a_o, e.b_o);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: got cycles=%0d exp below 100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    step("R1 reset clears both registers", 1, 0, 1, 1, 9'h1FF, 9'h1FF, 0, 0);
    step("R2 R9 isolation undriven zero",  0, 1, 0, 0, 9'h1FF, 9'h1FF, 0, 0);
    step("R4 capture A while isolated",    0, 1, 0, 0, 9'h1A5, 9'h000, 1, 0);
    step("R4 capture B while isolated",    0, 1, 0, 0, 9'h000, 9'h0F3, 0, 1);
    step("R7 stored exchange",             1, 0, 1, 1, 9'h000, 9'h000, 0, 0);
    step("R5 live A to B",                 1, 1, 0, 0, 9'h155, 9'h0C0, 0, 0);
    step("R5 stored A to B",               1, 1, 1, 0, 9'h155, 9'h0C0, 0, 0);
    step("R6 live B to A",                 0, 0, 0, 0, 9'h03C, 9'h0AA, 0, 0);
    step("R6 stored B to A",               0, 0, 0, 1, 9'h03C, 9'h0AA, 0, 0);
    step("R8 live B stored in both",       0, 0, 0, 0, 9'h1E1, 9'h133, 1, 1);
    step("R8 R7 both hold same value",     1, 0, 1, 1, 9'h000, 9'h000, 0, 0);
    step("R3 B captures own driven pin",   1, 1, 0, 0, 9'h07E, 9'h111, 0, 1);
    step("R3 R7 exchange after loop",      1, 0, 1, 1, 9'h000, 9'h000, 0, 0);
    step("R10 stored drive reloads B",     1, 1, 1, 0, 9'h0C3, 9'h0FF, 0, 1);
    step("R10 staggered A load",           1, 1, 1, 0, 9'h0C3, 9'h0FF, 1, 0);
    step("R10 R7 exchange after stagger",  1, 0, 1, 1, 9'h000, 9'h000, 0, 0);
    step("R4 both driven capture",         1, 0, 1, 1, 9'h0AB, 9'h0CD, 1, 1);
    step("R4 R7 exchange after swap",      1, 0, 1, 1, 9'h000, 9'h000, 0, 0);
    @(posedge clk);
    rst_n = 1'b0;
    m_ra = '0; m_rb = '0;
    @(posedge clk);
    rst_n = 1'b1;
    step("R1 mid-run reset clears",        1, 0, 1, 1, 9'h1FF, 9'h1FF, 0, 0);
    wait (q.size() == 0);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule